// File: doc/BRIEF.md
# Block-Scaled FP4 to FP32 Expander

This block turns a byte stream of packed 4-bit floating-point elements back into single-precision words. Data arrives in blocks of 32 elements. Each block opens with one scale byte, then 16 data bytes follow. Every data byte holds two elements. The element that comes first in the block sits in the low nibble.

Each nibble is a sign bit above a 3-bit magnitude code. The code picks one of eight grid values. The block scale is a pure power of two, and it is applied by adding an offset to the exponent field of the word. No multiplier is used. The result is one FP32 word per element, emitted in element order. A last flag marks the final element of each block.

Both the input and the output are valid/ready streams. When the consumer stalls the output, the block stops taking input bytes and no data is lost.

Top module: `fp4_block_dequant`

## Requirements
- R1: The magnitude codes 0 to 7 (nibble bits 2:0) decode to 0, 0.5, 1, 1.5, 2, 3, 4 and 6. With a scale byte of 127, the output is exactly the FP32 encoding of that value.
- R2: Nibble bit 3 is the sign and is copied to output bit 31. Code 0x8 produces negative zero (0x80000000).
- R3: A scale byte s multiplies the grid value by 2^(s-127). The block adds (s-127) to the FP32 exponent field (bits 30:23) and leaves the mantissa unchanged.
- R4: A zero magnitude code produces a signed zero for every scale value.
- R5: If the scaled biased exponent is 255 or more, the output is signed infinity: exponent 0xFF, mantissa 0.
- R6: If the scaled biased exponent is 0 or less, the output is signed zero.
- R7: The first byte of every block is the scale byte. The next 16 bytes are data bytes. In each data byte, bits 3:0 carry the earlier element and bits 7:4 the later one.
- R8: out_last is high on the 32nd output element of each block and low on every other element.
- R9: While out_valid is high and out_ready is low, out_data and out_last stay stable. No element is dropped or duplicated.
- R10: Output mantissa bits 21:0 are always zero. Only bit 22 can be set, and it carries the half-step of the grid values 1.5, 3 and 6.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Scale byte or packed data byte |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | FP32 element value |
| out_last | output | 1 | Final element of a block |

## Verification
The hardest situations to reach are at the edges of the exponent range. They need a scale byte near 0 or near 254, combined with the exact magnitude codes that land on exponent 0, exponent 1, exponent 254 or exponent 255. The stimulus includes blocks whose scales sit right at those edges. Each block repeats every sign and code combination twice, so every edge is crossed from both sides.

The second hard case is a stall that lands exactly on a block boundary, while the next scale byte is already waiting. Random and heavy backpressure phases run many blocks back to back so that such stalls occur.

// File: rtl/fp4dq_pkg.sv
`timescale 1ns/1ps
package fp4dq_pkg;

    localparam int BYTE_W      = 8;
    localparam int NIB_W       = 4;
    localparam int WORD_W      = 32;
    localparam int EXP_W       = 8;
    localparam int MAN_W       = 23;
    localparam int SCALE_BIAS  = 127;
    localparam int FP32_BIAS   = 127;
    localparam int EXP_MAX     = (1 << EXP_W) - 1;
    // exponent of the smallest nonzero grid value (0.5)
    localparam int GRID_EXP_LO = FP32_BIAS - 1;

    typedef enum logic {
        PH_SCALE = 1'b0,
        PH_DATA  = 1'b1
    } in_phase_t;

    typedef struct packed {
        logic [NIB_W-1:0]  code;
        logic [BYTE_W-1:0] scale;
        logic              last;
    } nib_item_t;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp32_t;

    typedef struct packed {
        logic  last;
        fp32_t word;
    } out_item_t;

    // Grid value -> FP32 with the block scale folded into the exponent.
    // Magnitude codes pair up per octave: code[2:1] selects the octave and
    // code[0] adds the half step, except for code 1 which is 0.5 exactly.
    function automatic fp32_t fp4_expand(input logic [NIB_W-1:0]  code,
                                         input logic [BYTE_W-1:0] scale);
        fp32_t      r;
        logic [1:0] octave;
        logic       half;
        int         e_sum;
        octave = code[2:1];
        half   = code[0] & (octave != 2'd0);
        e_sum  = GRID_EXP_LO + int'(octave) + int'(scale) - SCALE_BIAS;
        r.sign = code[NIB_W-1];
        r.exp  = '0;
        r.man  = '0;
        if (code[NIB_W-2:0] != '0) begin
            if (e_sum >= EXP_MAX) begin
                r.exp = EXP_W'(EXP_MAX);
            end else if (e_sum > 0) begin
                r.exp = e_sum[EXP_W-1:0];
                r.man = {half, {(MAN_W-1){1'b0}}};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/fp4dq_unpack.sv
`timescale 1ns/1ps
module fp4dq_unpack
    import fp4dq_pkg::*;
#(
    parameter int BLOCK_ELEMS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              nib_valid,
    input  logic              nib_ready,
    output nib_item_t         nib_item
);

    localparam int CNT_W = $clog2(BLOCK_ELEMS);

    in_phase_t         phase;
    logic [BYTE_W-1:0] scale_q;
    logic [BYTE_W-1:0] byte_q;
    logic              byte_vld;
    logic              hi_sel;
    logic [CNT_W-1:0]  elem_cnt;
    logic              is_last;
    logic              nib_fire;
    logic              in_fire;

    assign is_last   = (elem_cnt == CNT_W'(BLOCK_ELEMS - 1));
    assign nib_valid = byte_vld;
    assign nib_fire  = nib_valid && nib_ready;
    assign in_fire   = in_valid && in_ready;

    // A new data byte may enter while the high nibble of the held byte
    // leaves, except at the end of a block where a scale byte is due next.
    always_comb begin
        if (phase == PH_SCALE) begin
            in_ready = 1'b1;
        end else begin
            in_ready = !byte_vld || (hi_sel && nib_ready && !is_last);
        end
    end

    always_comb begin
        nib_item.code  = hi_sel ? byte_q[BYTE_W-1:NIB_W] : byte_q[NIB_W-1:0];
        nib_item.scale = scale_q;
        nib_item.last  = is_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_SCALE;
            scale_q  <= '0;
            byte_q   <= '0;
            byte_vld <= 1'b0;
            hi_sel   <= 1'b0;
            elem_cnt <= '0;
        end else begin
            if (nib_fire) begin
                elem_cnt <= is_last ? '0 : elem_cnt + 1'b1;
                if (hi_sel) begin
                    byte_vld <= 1'b0;
                    hi_sel   <= 1'b0;
                end else begin
                    hi_sel <= 1'b1;
                end
                if (is_last) begin
                    phase <= PH_SCALE;
                end
            end
            if (in_fire) begin
                if (phase == PH_SCALE) begin
                    scale_q <= in_data;
                    phase   <= PH_DATA;
                end else begin
                    byte_q   <= in_data;
                    byte_vld <= 1'b1;
                    hi_sel   <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/fp4dq_expand.sv
`timescale 1ns/1ps
module fp4dq_expand
    import fp4dq_pkg::*;
(
    input  nib_item_t nib_item,
    output out_item_t out_item
);

    always_comb begin
        out_item.word = fp4_expand(nib_item.code, nib_item.scale);
        out_item.last = nib_item.last;
    end

endmodule

// File: rtl/fp4dq_outreg.sv
`timescale 1ns/1ps
module fp4dq_outreg #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);

    logic         vld_q;
    logic [W-1:0] data_q;

    assign up_ready = !vld_q || dn_ready;
    assign dn_valid = vld_q;
    assign dn_data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            data_q <= '0;
        end else if (up_ready) begin
            vld_q <= up_valid;
            if (up_valid) begin
                data_q <= up_data;
            end
        end
    end

endmodule

// File: rtl/fp4_block_dequant.sv
`timescale 1ns/1ps
module fp4_block_dequant
    import fp4dq_pkg::*;
#(
    parameter int BLOCK_ELEMS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [7:0]  in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last
);

    localparam int ITEM_W = $bits(out_item_t);

    nib_item_t nib_item;
    logic      nib_valid;
    logic      nib_ready;
    out_item_t exp_item;
    out_item_t reg_item;

    fp4dq_unpack #(
        .BLOCK_ELEMS(BLOCK_ELEMS)
    ) u_unpack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .nib_valid(nib_valid),
        .nib_ready(nib_ready),
        .nib_item (nib_item)
    );

    fp4dq_expand u_expand (
        .nib_item(nib_item),
        .out_item(exp_item)
    );

    fp4dq_outreg #(
        .W(ITEM_W)
    ) u_outreg (
        .clk     (clk),
        .rst     (rst),
        .up_valid(nib_valid),
        .up_ready(nib_ready),
        .up_data (exp_item),
        .dn_valid(out_valid),
        .dn_ready(out_ready),
        .dn_data (reg_item)
    );

    assign out_data = reg_item.word;
    assign out_last = reg_item.last;

endmodule

// File: rtl/fp4dq_checker.sv
`timescale 1ns/1ps
module fp4dq_checker #(
    parameter int BLOCK_ELEMS = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last
);

    localparam int CNT_W = $clog2(BLOCK_ELEMS);

    logic [CNT_W-1:0] seen_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cnt <= '0;
        end else if (out_valid && out_ready) begin
            seen_cnt <= (seen_cnt == CNT_W'(BLOCK_ELEMS - 1)) ? '0 : seen_cnt + 1'b1;
        end
    end

    p_last_pos_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (seen_cnt == CNT_W'(BLOCK_ELEMS - 1))));

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    p_grid_mant_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data[21:0] == 22'd0));

    p_inf_clean_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[30:23] == 8'hFF) |-> !out_data[22]);

    p_flush_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data[30:23] == 8'h00) |-> (out_data[22:0] == 23'd0));

endmodule

bind fp4_block_dequant fp4dq_checker #(
    .BLOCK_ELEMS(BLOCK_ELEMS)
) u_fp4dq_checker (
    .clk      (clk),
    .rst      (rst),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last)
);

// File: tb/fp4_block_dequant_test.sv
`timescale 1ns/1ps
module fp4_block_dequant_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_last;

    always #2.5 clk = ~clk;

    fp4_block_dequant uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data),
        .out_last (out_last)
    );

    typedef struct {
        logic [31:0] word;
        logic        last;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    int          bp_mode = 0;
    int          cyc = 0;
    bit          done = 1'b0;
    logic [7:0]  blk [16];
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    logic        prev_last = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Model written from the requirements: grid constants plus exponent offset
    function automatic logic [31:0] model(input logic [3:0] nib, input logic [7:0] s);
        logic [31:0] base;
        int          e;
        case (nib[2:0])
            3'd0: base = 32'h0000_0000;
            3'd1: base = 32'h3F00_0000;
            3'd2: base = 32'h3F80_0000;
            3'd3: base = 32'h3FC0_0000;
            3'd4: base = 32'h4000_0000;
            3'd5: base = 32'h4040_0000;
            3'd6: base = 32'h4080_0000;
            default: base = 32'h40C0_0000;
        endcase
        if (base == 32'd0) return {nib[3], 31'd0};
        e = int'(base[30:23]) + int'(s) - 127;
        if (e >= 255) return {nib[3], 8'hFF, 23'd0};
        if (e <= 0) return {nib[3], 31'd0};
        return {nib[3], e[7:0], base[22:0]};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // R7: scale byte first, then 16 data bytes, low nibble first
    task automatic send_block(input logic [7:0] s, input string tag);
        send_byte(s);
        for (int i = 0; i < 16; i++) begin
            exp_t a;
            exp_t b;
            a.word = model(blk[i][3:0], s);
            a.last = 1'b0;
            a.tag  = tag;
            b.word = model(blk[i][7:4], s);
            b.last = (i == 15);
            b.tag  = tag;
            sb.push_back(a);
            sb.push_back(b);
            send_byte(blk[i]);
        end
    endtask

    task automatic fill_all_codes();
        for (int i = 0; i < 16; i++) begin
            blk[i] = {4'((2 * i + 1) % 16), 4'((2 * i) % 16)};
        end
    endtask

    task automatic fill_random();
        for (int i = 0; i < 16; i++) begin
            blk[i] = 8'($urandom);
        end
    endtask

    // backpressure generator
    always @(posedge clk) begin
        #1;
        case (bp_mode)
            0: out_ready = 1'b1;
            1: out_ready = ($urandom % 3) != 0;
            default: out_ready = ($urandom % 5) == 0;
        endcase
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data && out_last == prev_last,
                    "R9 stall hold", out_data, prev_data);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R9 unexpected output", out_data, 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(out_data == e.word, e.tag, out_data, e.word);
                    chk(out_last == e.last, "R8 last flag", 32'(out_last), 32'(e.last));
                    chk(out_data[21:0] == 22'd0, "R10 mantissa", out_data, {out_data[31:22], 22'd0});
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11 out_valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 1'b1, "R11 in_ready after reset", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1;

        // R1, R2, R7: every code at unity scale (includes 0x8 -> -0)
        fill_all_codes();
        send_block(8'd127, "R1 R2 unity grid");
        // R3: scaled up by 8
        send_block(8'd130, "R3 scale offset");
        // R3: scaled down by 1/16
        send_block(8'd123, "R3 scale offset down");
        // R5: overflow to infinity near the top
        send_block(8'd254, "R5 overflow");
        send_block(8'd253, "R5 overflow edge");
        // R6: underflow to zero near the bottom
        send_block(8'd0, "R6 underflow");
        send_block(8'd1, "R6 underflow edge");
        send_block(8'd2, "R6 smallest normal");
        // R4: zero codes with various scales
        for (int i = 0; i < 16; i++) blk[i] = (i % 2 == 0) ? 8'h80 : 8'h08;
        send_block(8'd200, "R4 signed zero");
        send_block(8'd255, "R4 signed zero max scale");

        // R9: random data under random backpressure
        bp_mode = 1;
        for (int n = 0; n < 20; n++) begin
            fill_random();
            send_block(8'($urandom_range(90, 170)), "R3 random block");
        end
        // R9: heavy backpressure with edge scales
        bp_mode = 2;
        fill_all_codes();
        send_block(8'd254, "R5 overflow stalled");
        send_block(8'd1, "R6 underflow stalled");
        for (int n = 0; n < 4; n++) begin
            fill_random();
            send_block(8'($urandom), "R9 random stalled");
        end

        while (sb.size() != 0) @(posedge clk);
        bp_mode = 0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 no extra output", 32'(out_valid), 32'd0);
        finish_run();
    end

endmodule